// File: doc/BRIEF.md
# Power Stage Fault Protection Controller

This block supervises a two-half-bridge switching output stage. It takes fault flags from the analog sensing circuits: overcurrent, overtemperature error, overtemperature warning and undervoltage. It also takes an active-low stage reset, a two-bit protection mode selector and the incoming PWM signal. From these it decides whether the bridge may switch (`stage_en`) or must sit in high impedance. It reports protection state on an active-low status output (`fault_n`) and temperature warnings on a separate active-low output (`warn_n`).

All asynchronous inputs pass through a multi-flop synchronizer. A fault sets a protection latch that mutes the stage at once. How the latch is released depends on the mode:

- **Latching mode:** only a stage reset toggle releases it.
- **Autorecovery mode:** a single shared counter of PWM cycles releases it in two steps. The latch clears halfway through the count, and switching resumes when the count is complete.
- **Test mode:** protection is ignored.

Top module: `pstage_guard`

## Requirements
- R1: With `mode_sel` at 00, 01 or 11, a high level on `flt_ocp`, `flt_ote` or `flt_uvp` drives `stage_en` low within three clock cycles. With `stage_rst_n` high it also drives `fault_n` low.
- R2: With `mode_sel` at 10 (test), the three fault flags have no effect: `stage_en` and `fault_n` stay high.
- R3: With `mode_sel` at 01 or 11 (latching), a captured fault persists after the flag is removed, whatever PWM activity follows. Only a falling edge of `stage_rst_n` clears it, and switching resumes when `stage_rst_n` returns high. A fault flag still present at that point latches again.
- R4: With `mode_sel` at 00 (autorecovery), rising edges of `pwm_in` are counted once the fault flag is gone:
  - At edge RECOV_CYCLES/2, `fault_n` returns high while `stage_en` stays low.
  - At edge RECOV_CYCLES, `stage_en` returns high.
- R5: A fault arriving while a recovery count runs sets the latch again and restarts the count from zero.
- R6: While `stage_rst_n` is low, `stage_en` is low and `fault_n` is high. A falling edge of `stage_rst_n` clears the latch and cancels any recovery count.
- R7: `flt_otw` high drives `warn_n` low in every mode, without affecting `stage_en` or `fault_n`.
- R8: After `rst_n` is released with `stage_rst_n` low, the outputs are `stage_en`=0, `fault_n`=1 and `warn_n`=1.
- R9: A fault that arrives while `stage_rst_n` is low is still latched. `fault_n` goes low once `stage_rst_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| stage_rst_n | input | 1 | Active-low stage reset / mute request |
| mode_sel | input | 2 | Protection mode: 00 autorecovery, 01 latching, 10 test, 11 latching |
| pwm_in | input | 1 | Incoming PWM signal, used as recovery time base |
| flt_ocp | input | 1 | Overcurrent flag |
| flt_ote | input | 1 | Overtemperature error flag |
| flt_otw | input | 1 | Overtemperature warning flag |
| flt_uvp | input | 1 | Undervoltage flag |
| stage_en | output | 1 | 1 = bridge switching, 0 = high impedance |
| fault_n | output | 1 | Low when protection is active and stage reset is high |
| warn_n | output | 1 | Low while overtemperature warning is present |

## Verification
The immediate fault response is swept across all four mode codes and all three fault sources. This separates the latching and autorecovery codes from the test code, and confirms that no source is left out.

The autorecovery sequence is driven one PWM pulse at a time, with checks one pulse before and at each of the half-count and full-count points. This catches off-by-one counting and a merged single-stage release.

Other sequences cover:
- faults injected mid-count, to show the restart;
- stage reset toggles with the fault flag still present or already removed;
- faults raised during mute;
- the warning flag in both test and latching modes.

// File: rtl/pstage_pkg.sv
package pstage_pkg;

   typedef enum logic [1:0] {
      PM_AUTO      = 2'b00,
      PM_LATCH     = 2'b01,
      PM_TEST      = 2'b10,
      PM_LATCH_ALT = 2'b11
   } prot_mode_e;

   localparam int FLAG_OCP = 0;
   localparam int FLAG_OTE = 1;
   localparam int FLAG_UVP = 2;
   localparam int FLAG_OTW = 3;
   localparam int FLAG_PWM = 4;
   localparam int FLAG_RST = 5;
   localparam int N_ASYNC  = 6;

   function automatic logic mode_is_latching(prot_mode_e m);
      return (m == PM_LATCH) || (m == PM_LATCH_ALT);
   endfunction

endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("pg_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stg[i] <= '0;
         else if (i == 0) stg[i] <= d;
         else             stg[i] <= stg[(i > 0) ? i-1 : 0];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pg_edge.sv
module pg_edge #(
   parameter bit RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic pulse
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end

   if (RISE) begin : g_rise
      assign pulse = lvl & ~prev;
   end else begin : g_fall
      assign pulse = ~lvl & prev;
   end
endmodule

// File: rtl/pg_recover.sv
module pg_recover #(
   parameter int CYCLES = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic abort,
   input  logic tick,
   output logic busy,
   output logic half_hit
);
   localparam int HALF = CYCLES / 2;
   localparam int CW   = $clog2(CYCLES + 1);

   logic [CW-1:0] cnt;
   logic          adv;

   if (CYCLES < 2 || (CYCLES % 2) != 0) begin : g_bad_cycles
      $error("pg_recover: CYCLES must be even and at least 2");
   end

   assign adv      = busy & tick & ~start & ~abort;
   assign half_hit = adv & (cnt == CW'(HALF - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (abort) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (adv) begin
         if (cnt == CW'(CYCLES - 1)) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R4: count never reaches the full window while still running
   a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt < CW'(CYCLES)));
   // R4: idle counter rests at zero
   a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cnt == '0));
   // R5: a start always yields a running count from zero
   a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && cnt == '0));
endmodule

// File: rtl/pstage_guard.sv
module pstage_guard
   import pstage_pkg::*;
#(
   parameter int RECOV_CYCLES = 512,
   parameter int SYNC_STAGES  = 2,
   parameter bit PWM_RISE     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stage_rst_n,
   input  logic [1:0] mode_sel,
   input  logic       pwm_in,
   input  logic       flt_ocp,
   input  logic       flt_ote,
   input  logic       flt_otw,
   input  logic       flt_uvp,
   output logic       stage_en,
   output logic       fault_n,
   output logic       warn_n
);
   logic [N_ASYNC-1:0] raw, syn;
   prot_mode_e         mode;
   logic               err_now, rst_s, rst_q, rst_fall;
   logic               pwm_tick, rec_busy, rec_half;
   logic               prot_latch;

   assign raw[FLAG_OCP] = flt_ocp;
   assign raw[FLAG_OTE] = flt_ote;
   assign raw[FLAG_UVP] = flt_uvp;
   assign raw[FLAG_OTW] = flt_otw;
   assign raw[FLAG_PWM] = pwm_in;
   assign raw[FLAG_RST] = stage_rst_n;

   pg_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(syn));

   pg_edge #(.RISE(PWM_RISE)) u_pwm_edge (
      .clk(clk), .rst_n(rst_n), .lvl(syn[FLAG_PWM]), .pulse(pwm_tick));

   assign mode     = prot_mode_e'(mode_sel);
   assign rst_s    = syn[FLAG_RST];
   assign err_now  = (syn[FLAG_OCP] | syn[FLAG_OTE] | syn[FLAG_UVP])
                     & (mode != PM_TEST);
   assign rst_fall = rst_q & ~rst_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_q <= 1'b0;
      else        rst_q <= rst_s;
   end

   pg_recover #(.CYCLES(RECOV_CYCLES)) u_recover (
      .clk(clk), .rst_n(rst_n),
      .start(err_now & (mode == PM_AUTO)),
      .abort(rst_fall),
      .tick(pwm_tick),
      .busy(rec_busy),
      .half_hit(rec_half));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   prot_latch <= 1'b0;
      else if (err_now)             prot_latch <= 1'b1;
      else if (rst_fall | rec_half) prot_latch <= 1'b0;
   end

   assign stage_en = rst_s & ~prot_latch & ~rec_busy;
   assign fault_n  = ~(prot_latch & rst_s);
   assign warn_n   = ~syn[FLAG_OTW];

   // R1: a qualified fault mutes the stage on the next cycle
   a_r1_fault_mutes: assert property (@(posedge clk) disable iff (!rst_n)
      err_now |=> !stage_en);
   // R3: in latching modes the latch only drops on a reset falling edge
   a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_latch && mode_is_latching(mode) && !rst_fall) |=> prot_latch);
   // R2: test mode never raises the latch from a clear state
   a_r2_test_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_TEST && !prot_latch) |=> !prot_latch);
   // R6: a reset falling edge leaves no latch or count behind unless a fault is live
   a_r6_rst_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_fall && !err_now) |=> (!prot_latch && !rec_busy));
endmodule

// File: tb/pstage_guard_bench.sv
module pstage_guard_bench;
   localparam int N = 8;

   logic clk = 1'b0;
   logic rst_n, stage_rst_n, pwm_in, flt_ocp, flt_ote, flt_otw, flt_uvp;
   logic [1:0] mode_sel;
   logic stage_en, fault_n, warn_n;
   int checks = 0, errors = 0;

   always #10 clk = ~clk;

   pstage_guard #(.RECOV_CYCLES(N)) u_pstage_guard (
      .clk(clk), .rst_n(rst_n), .stage_rst_n(stage_rst_n), .mode_sel(mode_sel),
      .pwm_in(pwm_in), .flt_ocp(flt_ocp), .flt_ote(flt_ote), .flt_otw(flt_otw),
      .flt_uvp(flt_uvp), .stage_en(stage_en), .fault_n(fault_n), .warn_n(warn_n));

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic chk3(string req, logic e_en, logic e_fn, logic e_wn);
      chk(req, "stage_en", stage_en, e_en);
      chk(req, "fault_n",  fault_n,  e_fn);
      chk(req, "warn_n",   warn_n,   e_wn);
   endtask

   task automatic pulse(int n);
      for (int i = 0; i < n; i++) begin
         pwm_in = 1'b1; step(4);
         pwm_in = 1'b0; step(4);
      end
   endtask

   task automatic set_flag(int s, logic v);
      case (s)
         0: flt_ocp = v;
         1: flt_ote = v;
         default: flt_uvp = v;
      endcase
   endtask

   task automatic clear_all();
      flt_ocp = 0; flt_ote = 0; flt_uvp = 0; flt_otw = 0; pwm_in = 0;
      stage_rst_n = 1'b0; step(6);
      stage_rst_n = 1'b1; step(6);
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
   end

   initial begin
      rst_n = 0; stage_rst_n = 0; mode_sel = 2'b00; pwm_in = 0;
      flt_ocp = 0; flt_ote = 0; flt_otw = 0; flt_uvp = 0;
      step(3); rst_n = 1; step(4);
      chk3("R8", 1'b0, 1'b1, 1'b1);
      stage_rst_n = 1; step(6);
      chk3("R8 run", 1'b1, 1'b1, 1'b1);

      // R1/R2/R3 sweep over every mode code and fault source
      for (int m = 0; m < 4; m++) begin
         for (int s = 0; s < 3; s++) begin
            mode_sel = 2'(m);
            clear_all();
            set_flag(s, 1'b1); step(5);
            if (m == 2) chk3("R2", 1'b1, 1'b1, 1'b1);
            else        chk3("R1", 1'b0, 1'b0, 1'b1);
            set_flag(s, 1'b0); step(5);
            pulse(3);
            if (m == 2) chk3("R2 after", 1'b1, 1'b1, 1'b1);
            else        chk3("R3/R4 held", 1'b0, 1'b0, 1'b1);
         end
      end

      // R4 two-stage autorecovery
      mode_sel = 2'b00; clear_all();
      flt_uvp = 1; step(5); flt_uvp = 0; step(5);
      pulse(N/2 - 1); chk3("R4 pre-half", 1'b0, 1'b0, 1'b1);
      pulse(1);       chk3("R4 half", 1'b0, 1'b1, 1'b1);
      pulse(N/2 - 1); chk3("R4 pre-full", 1'b0, 1'b1, 1'b1);
      pulse(1);       chk3("R4 full", 1'b1, 1'b1, 1'b1);

      // R5 restart on a fault mid-count
      clear_all();
      flt_ote = 1; step(5); flt_ote = 0; step(5);
      pulse(N/2 + 1);
      flt_ocp = 1; step(5); chk3("R5 relatch", 1'b0, 1'b0, 1'b1);
      flt_ocp = 0; step(5);
      pulse(N/2 - 1); chk3("R5 restarted", 1'b0, 1'b0, 1'b1);
      pulse(1);       chk3("R5 half", 1'b0, 1'b1, 1'b1);
      pulse(N/2);     chk3("R5 full", 1'b1, 1'b1, 1'b1);

      // R6 reset aborts recovery
      clear_all();
      flt_ocp = 1; step(5); flt_ocp = 0; step(5);
      pulse(2);
      stage_rst_n = 0; step(6); chk3("R6 mute", 1'b0, 1'b1, 1'b1);
      stage_rst_n = 1; step(6); chk3("R6 resume", 1'b1, 1'b1, 1'b1);

      // R3 latching reset with fault still present
      mode_sel = 2'b01; clear_all();
      flt_ocp = 1; step(5);
      stage_rst_n = 0; step(6); chk3("R6 mute latched", 1'b0, 1'b1, 1'b1);
      stage_rst_n = 1; step(6); chk3("R3 relatch", 1'b0, 1'b0, 1'b1);
      flt_ocp = 0; step(5);
      stage_rst_n = 0; step(6); stage_rst_n = 1; step(6);
      chk3("R3 release", 1'b1, 1'b1, 1'b1);

      // R9 fault during mute
      mode_sel = 2'b11; clear_all();
      stage_rst_n = 0; step(6);
      flt_uvp = 1; step(5); flt_uvp = 0; step(5);
      chk3("R9 muted", 1'b0, 1'b1, 1'b1);
      stage_rst_n = 1; step(6); chk3("R9 reported", 1'b0, 1'b0, 1'b1);

      // R7 warning in test and latching modes
      for (int m = 1; m < 3; m++) begin
         mode_sel = 2'(m); clear_all();
         flt_otw = 1; step(5); chk3("R7 warn", 1'b1, 1'b1, 1'b0);
         flt_otw = 0; step(5); chk3("R7 clear", 1'b1, 1'b1, 1'b1);
      end

      report();
   end
endmodule